// File: doc/BRIEF.md
# Fast CPU Reset and A20 Gate Control Port

This block is a single 8-bit control register on the host I/O space, decoded at address 92h. Software uses it for two jobs. The low bit starts a timed reset pulse for the processor. This path is much quicker than going through the keyboard controller. The next bit drives the alternate A20 gate line straight from its stored value. Reads return both control bits together with a fixed pattern in the upper six bits, so the register reads 24h after reset.

The reset pulse comes from a small sequencer with a delay counter followed by a width counter. Once the sequencer has run, it stays spent until software writes the arm bit back to 0. The pulse only runs while the port-enable input is high. The active-low result is ANDed with the keyboard controller's active-low reset. A polarity input then sets the sense of the reset pin.

The host side is a plain strobe bus. A write is taken on any clock edge where the write strobe is high and the address matches. Read data is combinational and valid in the same cycle as the read strobe. The bus has no wait states and no back-pressure, because the register always accepts and answers at once.

Top module: `fastrst_port`

## Requirements
- R1: After reset the register reads 24h, `a20_out` is 0 and the internal alternate reset is inactive, so `sys_rst_out` is 1 when `rst_pol`=0 and `kbc_rst_n`=1.
- R2: With `bus_rd`=1 and `bus_addr`=92h, `bus_rdata` in the same cycle is {2'b00, 1'b1, 2'b00, 1'b1, A20 bit, arm bit}. Bit 1 is the A20 bit and bit 0 is the arm bit. Any other address, or `bus_rd`=0, gives 00h.
- R3: A write at 92h stores `bus_wdata[1:0]`. Write data in bits 7:2 has no effect. Writes to any other address change nothing.
- R4: `a20_out` equals the stored A20 bit from the clock edge after the write.
- R5: Take a write of 1 to the arm bit while it is 0 and `port_en`=1, captured at edge k. The alternate reset stays inactive for exactly DLY_CYC cycles. It is then active (low) for exactly PW_CYC cycles, covering edges k+DLY_CYC to k+DLY_CYC+PW_CYC.
- R6: Writing 1 to the arm bit while it is already 1 has no effect. It neither restarts a running delay nor produces a second pulse. A new pulse needs the bit to be written back to 0 first.
- R7: Writing 0 to the arm bit during the delay or the pulse aborts the sequence. The alternate reset is inactive from the next edge and no pulse follows.
- R8: With `port_en`=0 an arming write produces no pulse and uses up the arming, so raising `port_en` later does not fire it. Dropping `port_en` during the delay or the pulse aborts it.
- R9: The internal alternate reset is ANDed with `kbc_rst_n`. Either source being low makes the combined reset active, and the path from `kbc_rst_n` has no register.
- R10: When `rst_pol`=0, `sys_rst_out` carries the combined reset as active low. When `rst_pol`=1 it carries the inverted, active-high version.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, synchronous |
| bus_addr | input | ADDR_W (16) | Host I/O address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read strobe cycle |
| port_en | input | 1 | Enables the reset pulse path |
| kbc_rst_n | input | 1 | Keyboard-controller reset, active low |
| rst_pol | input | 1 | 0: active-low reset pin, 1: active-high |
| a20_out | output | 1 | Alternate A20 gate |
| sys_rst_out | output | 1 | Combined CPU reset after the polarity stage |

## Verification
Several properties are checked on every cycle. A pulse may only begin straight out of the delay state. A spent sequencer stays spent while the arm bit is held. A clearing write, or a low `port_en`, leaves the pulse inactive on the next edge. The A20 line follows the last write. Other things only the directed scenarios can show: the exact delay and width counts, that a repeated arming write is ignored, that a disabled arming is consumed, that the read-back value is right, and how the keyboard reset combines with the polarity stage.

// File: rtl/fastrst_pkg.sv
package fastrst_pkg;

  // Sequencer states for the timed reset pulse
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2,
    ST_DONE  = 2'd3
  } fr_state_t;

  // Read-only upper six bits of the register (bits 7:2)
  localparam logic [5:0] FR_FIXED_HI = 6'b001001;

  // Register width
  localparam int FR_DATA_W = 8;

endpackage

// File: rtl/fastrst_regs.sv
module fastrst_regs
  import fastrst_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PORT_ADDR = 16'h0092
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [FR_DATA_W-1:0] bus_wdata,
  output logic [FR_DATA_W-1:0] bus_rdata,
  output logic                 arm_bit,
  output logic                 arm_set,
  output logic                 arm_clr,
  output logic                 a20_out
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(PORT_ADDR);

  logic hit;
  logic wr_hit;
  logic arm_q;
  logic a20_q;

  assign hit    = (bus_addr == HIT_ADDR);
  assign wr_hit = bus_wr && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      a20_q <= 1'b0;
    end else if (wr_hit) begin
      arm_q <= bus_wdata[0];
      a20_q <= bus_wdata[1];
    end
  end

  // Arming happens on the 0 -> 1 transition only; clearing on any write of 0
  assign arm_set = wr_hit && bus_wdata[0] && !arm_q;
  assign arm_clr = wr_hit && !bus_wdata[0];
  assign arm_bit = arm_q;
  assign a20_out = a20_q;

  always_comb begin
    if (bus_rd && hit) bus_rdata = {FR_FIXED_HI, a20_q, arm_q};
    else               bus_rdata = '0;
  end

  // R4: the gate line follows the data of the last accepted write
  a_r4_a20_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (a20_out == $past(bus_wdata[1])));

endmodule

// File: rtl/fastrst_seq.sv
module fastrst_seq
  import fastrst_pkg::*;
#(
  parameter int DLY_CYC = 700,
  parameter int PW_CYC  = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic arm_clr,
  input  logic arm_bit,
  input  logic port_en,
  output logic pulse_n
);

  localparam int MAX_CYC = (DLY_CYC > PW_CYC) ? DLY_CYC : PW_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_CYC - 1);
  localparam logic [CNT_W-1:0] PW_LAST  = CNT_W'(PW_CYC - 1);

  fr_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_n_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (arm_set) state_d = port_en ? ST_DELAY : ST_DONE;
      end
      ST_DELAY: begin
        if (arm_clr) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (!port_en) begin
          state_d = ST_DONE;
          cnt_d   = '0;
        end else if (cnt_q == DLY_LAST) begin
          state_d = ST_PULSE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_PULSE: begin
        if (arm_clr) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (!port_en) begin
          state_d = ST_DONE;
          cnt_d   = '0;
        end else if (cnt_q == PW_LAST) begin
          state_d = ST_DONE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_DONE: begin
        cnt_d = '0;
        if (arm_clr || !arm_bit) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      pulse_n_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      pulse_n_q <= (state_d != ST_PULSE);
    end
  end

  assign pulse_n = pulse_n_q;

  // R5: the output only goes active straight out of the delay phase
  a_r5_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_n_q) |-> ($past(state_q) == ST_DELAY));

  // R6: a spent sequencer stays spent while the arm bit is held at 1
  a_r6_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && arm_bit && !arm_clr) |=> (state_q == ST_DONE));

  // R7: a clearing write releases the pulse on the next edge
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr |=> pulse_n_q);

  // R8: no active pulse after a cycle with the port disabled
  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> pulse_n_q);

endmodule

// File: rtl/fastrst_outstage.sv
module fastrst_outstage (
  input  logic pulse_n,
  input  logic kbc_rst_n,
  input  logic rst_pol,
  output logic sys_rst_out
);

  logic comb_rst_n;

  // R9: either source drives the combined reset active
  assign comb_rst_n  = pulse_n & kbc_rst_n;
  // R10: polarity stage
  assign sys_rst_out = rst_pol ? ~comb_rst_n : comb_rst_n;

  always_comb begin
    if (!kbc_rst_n) a_r9_kbc_wins: assert (sys_rst_out == rst_pol);
  end

endmodule

// File: rtl/fastrst_port.sv
module fastrst_port
  import fastrst_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PORT_ADDR = 16'h0092,
  parameter int          DLY_CYC   = 700,
  parameter int          PW_CYC    = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              port_en,
  input  logic              kbc_rst_n,
  input  logic              rst_pol,
  output logic              a20_out,
  output logic              sys_rst_out
);

  logic arm_bit;
  logic arm_set;
  logic arm_clr;
  logic pulse_n;

  fastrst_regs #(
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .arm_bit   (arm_bit),
    .arm_set   (arm_set),
    .arm_clr   (arm_clr),
    .a20_out   (a20_out)
  );

  fastrst_seq #(
    .DLY_CYC (DLY_CYC),
    .PW_CYC  (PW_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_set (arm_set),
    .arm_clr (arm_clr),
    .arm_bit (arm_bit),
    .port_en (port_en),
    .pulse_n (pulse_n)
  );

  fastrst_outstage u_out (
    .pulse_n     (pulse_n),
    .kbc_rst_n   (kbc_rst_n),
    .rst_pol     (rst_pol),
    .sys_rst_out (sys_rst_out)
  );

endmodule

// File: tb/fastrst_port_tb.sv
module fastrst_port_tb;

  localparam int DLY = 40;
  localparam int PW  = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        port_en;
  logic        kbc_rst_n;
  logic        rst_pol;
  logic        a20_out;
  logic        sys_rst_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fastrst_port #(
    .ADDR_W (16), .PORT_ADDR (16'h0092), .DLY_CYC (DLY), .PW_CYC (PW)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .port_en (port_en), .kbc_rst_n (kbc_rst_n), .rst_pol (rst_pol),
    .a20_out (a20_out), .sys_rst_out (sys_rst_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write is taken at the next posedge; returns at the following negedge
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1 d = bus_rdata;
    bus_rd   = 1'b0;
  endtask

  // Counts inactive then active negedges of sys_rst_out (rst_pol=0, kbc high)
  task automatic measure(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (sys_rst_out && hi < 4 * DLY) begin hi++; @(negedge clk); end
    while (!sys_rst_out && lo < 4 * PW) begin lo++; @(negedge clk); end
  endtask

  // Returns 1 if sys_rst_out stayed high for n negedges
  task automatic stays_high(input int n, output int ok);
    ok = 1;
    for (int i = 0; i < n; i++) begin
      if (!sys_rst_out) ok = 0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(16'h0092, d);
    chk("R1 reset read", d, 8'h24);
    chk("R1 reset a20", a20_out, 0);
    chk("R1 reset pin", sys_rst_out, 1);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    bus_write(16'h0093, 8'h03);
    bus_read(16'h0092, d);
    chk("R3 other addr write ignored", d, 8'h24);
    chk("R3 other addr a20", a20_out, 0);
    bus_write(16'h0092, 8'hFC);
    bus_read(16'h0092, d);
    chk("R3 upper bits ignored", d, 8'h24);
    bus_write(16'h0092, 8'h02);
    chk("R4 a20 high", a20_out, 1);
    bus_read(16'h0092, d);
    chk("R2 read a20 bit", d, 8'h26);
    bus_read(16'h0091, d);
    chk("R2 other addr reads zero", d, 8'h00);
    bus_addr = 16'h0092;
    #1 chk("R2 no strobe reads zero", bus_rdata, 8'h00);
    bus_write(16'h0092, 8'h00);
    chk("R4 a20 low", a20_out, 0);
  endtask

  task automatic t_pulse();
    int hi, lo, ok;
    logic [7:0] d;
    bus_write(16'h0092, 8'h01);
    measure(hi, lo);
    chk("R5 delay cycles", hi, DLY);
    chk("R5 width cycles", lo, PW);
    bus_read(16'h0092, d);
    chk("R2 arm bit reads back", d, 8'h25);
    bus_write(16'h0092, 8'h01);
    stays_high(DLY + PW + 10, ok);
    chk("R6 no second pulse while armed", ok, 1);
    bus_write(16'h0092, 8'h00);
    bus_write(16'h0092, 8'h01);
    measure(hi, lo);
    chk("R6 re-armed pulse delay", hi, DLY);
    chk("R6 re-armed pulse width", lo, PW);
    bus_write(16'h0092, 8'h00);
  endtask

  task automatic t_retrigger();
    int hi, lo;
    bus_write(16'h0092, 8'h01);
    repeat (9) @(negedge clk);
    bus_write(16'h0092, 8'h01);
    measure(hi, lo);
    chk("R6 rewrite does not restart delay", hi, DLY - 10);
    chk("R6 rewrite pulse width", lo, PW);
    bus_write(16'h0092, 8'h00);
  endtask

  task automatic t_abort();
    int ok;
    logic [7:0] d;
    bus_write(16'h0092, 8'h01);
    repeat (5) @(negedge clk);
    bus_write(16'h0092, 8'h00);
    stays_high(DLY + PW + 5, ok);
    chk("R7 abort in delay", ok, 1);
    bus_read(16'h0092, d);
    chk("R7 arm bit cleared", d, 8'h24);
    bus_write(16'h0092, 8'h01);
    repeat (DLY + 3) @(negedge clk);
    chk("R5 active mid pulse", sys_rst_out, 0);
    bus_write(16'h0092, 8'h00);
    chk("R7 abort in pulse releases", sys_rst_out, 1);
    stays_high(PW + 5, ok);
    chk("R7 stays released", ok, 1);
  endtask

  task automatic t_disable();
    int ok, hi, lo;
    port_en = 1'b0;
    bus_write(16'h0092, 8'h01);
    stays_high(DLY + PW + 5, ok);
    chk("R8 no pulse when disabled", ok, 1);
    port_en = 1'b1;
    stays_high(DLY + PW + 5, ok);
    chk("R8 arming consumed", ok, 1);
    bus_write(16'h0092, 8'h00);
    bus_write(16'h0092, 8'h01);
    repeat (5) @(negedge clk);
    port_en = 1'b0;
    @(negedge clk);
    port_en = 1'b1;
    stays_high(DLY + PW + 5, ok);
    chk("R8 disable aborts delay", ok, 1);
    bus_write(16'h0092, 8'h00);
    bus_write(16'h0092, 8'h01);
    measure(hi, lo);
    chk("R8 enabled pulse delay", hi, DLY);
    chk("R8 enabled pulse width", lo, PW);
    bus_write(16'h0092, 8'h00);
  endtask

  task automatic t_combine();
    kbc_rst_n = 1'b0;
    #1 chk("R9 kbc asserts reset", sys_rst_out, 0);
    rst_pol = 1'b1;
    #1 chk("R10 kbc reset active high", sys_rst_out, 1);
    kbc_rst_n = 1'b1;
    #1 chk("R10 idle active high pin", sys_rst_out, 0);
    @(negedge clk);
    bus_write(16'h0092, 8'h01);
    repeat (DLY + 2) @(negedge clk);
    chk("R10 pulse active high", sys_rst_out, 1);
    kbc_rst_n = 1'b0;
    #1 chk("R9 both sources active", sys_rst_out, 1);
    kbc_rst_n = 1'b1;
    rst_pol = 1'b0;
    @(negedge clk);
    bus_write(16'h0092, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    port_en = 1'b1; kbc_rst_n = 1'b1; rst_pol = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_pulse();
    t_retrigger();
    t_abort();
    t_disable();
    t_combine();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule